// File: doc/BRIEF.md
# Ping-Pong Drop-Detector Frequency Controller

This block is the digital frequency loop for one switched-capacitor converter. It holds the oscillator frequency code. A slow regulation path reads a comparator that reports whether the converter output is below its reference. On every fourth control tick it raises the code by one while the output is low and lowers it by one otherwise. The code saturates at both ends.

Two external fast drop detectors must be reset periodically. The block runs them on a shared 64-tick schedule, offset by half a period, so that one detector is always armed while the other is held in reset. A rising drop indication from an armed detector forces the code straight to its maximum. The slow path then walks the code back down toward the level the sustained load needs.

All control logic advances on a tick derived from the converter clock. The tick comes once every 2^div_sel clock cycles, so the speed of the loop follows the converter's own switching rate.

Top module: `drop_freq_ctrl`

## Requirements
- R1: While reset is asserted, freq_code is 0, det_rst_a is 1 and det_rst_b is 0.
- R2: The control tick occurs once every 2^div_sel clock cycles. A new div_sel value is taken up only at the next tick, and the tick immediately after reset release is always on the first clock edge. Between ticks freq_code and the detector reset outputs do not change.
- R3: Without a drop event, freq_code changes only on every fourth tick. It goes up by 1 when below_ref is 1 at that tick and down by 1 when below_ref is 0.
- R4: freq_code never wraps. It stays at 63 when a step up is due and at 0 when a step down is due.
- R5: The tick counter cycles through phases 0..63, where phase p holds after tick p (mod 64) since reset. det_rst_a is 1 exactly in phases 0..3 and det_rst_b is 1 exactly in phases 32..35. The two are never 1 together.
- R6: Each drop input passes through two sampling stages and then an edge detector. Suppose a drop input rises before tick e and the detector is accepted. Then freq_code is 63 after tick e+2, and the four-tick step count restarts from that tick.
- R7: A detector's rising edge is ignored when the phase before the accepting tick lies in its reset window or in the first phase after release. For detector A this is phases 0..4; for detector B it is phases 32..36.
- R8: A drop input held high causes only one forced maximum; afterward the code moves only by the slow path.
- R9: After a forced maximum with below_ref at 0, freq_code falls by 1 every fourth tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | Tick divider exponent, ratio 2^div_sel |
| below_ref | input | 1 | Comparator: output is below reference |
| drop_a | input | 1 | Drop indication from detector A |
| drop_b | input | 1 | Drop indication from detector B |
| freq_code | output | 6 | Oscillator frequency code |
| det_rst_a | output | 1 | Holds detector A in reset |
| det_rst_b | output | 1 | Holds detector B in reset |

## Verification
Slow-path steps take effect on the 4th, 8th, 12th... tick after reset, or on the 4th tick after a forced maximum. A forced maximum appears on the third tick after the drop input rises, two ticks for sampling and one for the edge. Detector reset outputs follow the phase after every tick with no added delay. The bench counts clock edges since reset release and samples each output on the falling edge right after the tick at which that result is due, and also one tick before, to confirm it does not arrive early. For the divided-tick cases it computes the tick edges from the ratio that was in force at the previous tick.

// File: rtl/drop_freq_ctrl.sv
module drop_freq_ctrl #(
  parameter int CODE_W     = 6,
  parameter int SEL_W      = 3,
  parameter int STEP_TICKS = 4,
  parameter int SCHED_LEN  = 64,
  parameter int RST_TICKS  = 4,
  parameter int B_OFFSET   = 32,
  parameter int RESET_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              below_ref,
  input  logic              drop_a,
  input  logic              drop_b,
  output logic [CODE_W-1:0] freq_code,
  output logic              det_rst_a,
  output logic              det_rst_b
);
  localparam int DIV_W = 2**SEL_W - 1;
  localparam int PH_W  = $clog2(SCHED_LEN);
  localparam int ST_W  = $clog2(STEP_TICKS);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [DIV_W-1:0]  DIV_ONES = '1;

  logic [DIV_W-1:0] div_cnt;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_mask;
  logic             tick;

  assign div_mask = ~(DIV_ONES << sel_q);
  assign tick     = (div_cnt == div_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sel_q   <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sel_q   <= div_sel;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (tick)
      phase <= (phase == PH_W'(SCHED_LEN-1)) ? '0 : phase + 1'b1;
  end

  logic [1:0] drop_in;
  logic [1:0] in_rst;
  logic [1:0] hit;
  assign drop_in = {drop_b, drop_a};

  for (genvar d = 0; d < 2; d++) begin : g_det
    logic [PH_W-1:0] rel;
    logic [2:0]      sh;
    assign rel       = phase - PH_W'(d * B_OFFSET);
    assign in_rst[d] = (rel < PH_W'(RST_TICKS));
    assign hit[d]    = sh[1] & ~sh[2] & (rel > PH_W'(RST_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh <= '0;
      else if (tick)
        sh <= {sh[1:0], drop_in[d]};
    end
  end

  assign det_rst_a = in_rst[0];
  assign det_rst_b = in_rst[1];

  logic [ST_W-1:0] step_cnt;
  logic            step_fire;
  logic            drop_evt;

  assign drop_evt  = tick & (|hit);
  assign step_fire = tick & (step_cnt == ST_W'(STEP_TICKS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt  <= '0;
      freq_code <= CODE_W'(RESET_CODE);
    end else if (drop_evt) begin
      step_cnt  <= '0;
      freq_code <= CODE_MAX;
    end else if (step_fire) begin
      step_cnt <= '0;
      if (below_ref)
        freq_code <= (freq_code == CODE_MAX) ? freq_code : freq_code + 1'b1;
      else
        freq_code <= (freq_code == '0) ? freq_code : freq_code - 1'b1;
    end else if (tick) begin
      step_cnt <= step_cnt + 1'b1;
    end
  end

  p_one_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_rst_a && det_rst_b));

  p_drop_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (freq_code == CODE_MAX));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> (freq_code == $past(freq_code) ||
                   freq_code == $past(freq_code) + 1'b1 ||
                   freq_code == $past(freq_code) - 1'b1));

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop_evt && !step_fire) |=> $stable(freq_code));

  p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code == CODE_MAX && below_ref && !drop_evt) |=> (freq_code == CODE_MAX));

  p_no_wrap_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code == '0 && !below_ref && !drop_evt) |=> (freq_code == '0));

  p_idle_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(freq_code) && $stable(det_rst_a) && $stable(det_rst_b)));

endmodule

// File: tb/drop_freq_ctrl_bench.sv
module drop_freq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       below_ref = 1'b0;
  logic       drop_a = 1'b0;
  logic       drop_b = 1'b0;
  logic [5:0] freq_code;
  logic       det_rst_a;
  logic       det_rst_b;

  int n_run = 0;
  int n_fail = 0;
  int edge_n = 0;
  bit finished = 0;

  drop_freq_ctrl u_drop_freq_ctrl (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .below_ref(below_ref),
    .drop_a(drop_a), .drop_b(drop_b), .freq_code(freq_code),
    .det_rst_a(det_rst_a), .det_rst_b(det_rst_b)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (edge_n < n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input logic [2:0] sel, input logic below);
    div_sel = sel; below_ref = below; drop_a = 1'b0; drop_b = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; below_ref = 1'b1; drop_a = 1'b1; drop_b = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 code", freq_code, 0);
    chk("R1 det_rst_a", det_rst_a, 1);
    chk("R1 det_rst_b", det_rst_b, 0);
  endtask

  task automatic t_climb;
    do_reset(3'd0, 1'b1);
    wait_to(3); chk("R3 before step", freq_code, 0);
    wait_to(4); chk("R3 first step", freq_code, 1);
    wait_to(7); chk("R3 hold", freq_code, 1);
    wait_to(8); chk("R3 second step", freq_code, 2);
  endtask

  task automatic t_floor;
    do_reset(3'd0, 1'b0);
    wait_to(9); chk("R4 floor", freq_code, 0);
  endtask

  task automatic t_schedule;
    int bad_a = 0, bad_b = 0, both = 0;
    do_reset(3'd0, 1'b0);
    for (int k = 1; k <= 140; k++) begin
      int ph;
      wait_to(k);
      ph = k % 64;
      if (det_rst_a != (ph < 4)) bad_a++;
      if (det_rst_b != (ph >= 32 && ph < 36)) bad_b++;
      if (det_rst_a && det_rst_b) both++;
    end
    chk("R5 A schedule mismatches", bad_a, 0);
    chk("R5 B schedule mismatches", bad_b, 0);
    chk("R5 both in reset", both, 0);
  endtask

  task automatic t_drop_b;
    do_reset(3'd0, 1'b1);
    wait_to(4); chk("R3 step before drop", freq_code, 1);
    drop_b = 1'b1;
    wait_to(6); chk("R6 not yet forced", freq_code, 1);
    wait_to(7); chk("R6 forced max", freq_code, 63);
    wait_to(11); chk("R4 top saturation", freq_code, 63);
    wait_to(12); below_ref = 1'b0;
    wait_to(15); chk("R9 walk down 1", freq_code, 62);
    wait_to(19); chk("R9 walk down 2", freq_code, 61);
    wait_to(23); chk("R8 held drop no retrigger", freq_code, 60);
  endtask

  task automatic t_blind_a;
    do_reset(3'd0, 1'b0);
    wait_to(2); drop_a = 1'b1;
    wait_to(5); chk("R7 A ignored one after release", freq_code, 0);
    wait_to(10); chk("R7 A no late event", freq_code, 0);
    wait_to(12); drop_a = 1'b0;
    wait_to(19); drop_a = 1'b1;
    wait_to(21); chk("R6 A not yet forced", freq_code, 0);
    wait_to(22); chk("R6 A forced max", freq_code, 63);
  endtask

  task automatic t_first_valid_a;
    do_reset(3'd0, 1'b0);
    wait_to(3); drop_a = 1'b1;
    wait_to(5); chk("R7 A boundary pending", freq_code, 0);
    wait_to(6); chk("R7 A first accepted phase", freq_code, 63);
  endtask

  task automatic t_blind_b;
    do_reset(3'd0, 1'b0);
    wait_to(34); drop_b = 1'b1;
    wait_to(37); chk("R7 B ignored one after release", freq_code, 0);
    wait_to(45); chk("R7 B no late event", freq_code, 0);
  endtask

  task automatic t_divider;
    do_reset(3'd2, 1'b1);
    wait_to(12); chk("R2 ratio4 before step", freq_code, 0);
    wait_to(13); chk("R2 ratio4 first step", freq_code, 1);
    wait_to(28); chk("R2 ratio4 hold", freq_code, 1);
    wait_to(29); chk("R2 ratio4 second step", freq_code, 2);
    wait_to(30); div_sel = 3'd0;
    wait_to(35); chk("R2 ratio change pending", freq_code, 2);
    wait_to(36); chk("R2 ratio change applied", freq_code, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_climb;
    t_floor;
    t_schedule;
    t_drop_b;
    t_blind_a;
    t_first_valid_a;
    t_blind_b;
    t_divider;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule